// File: doc/BRIEF.md
# Load Permission Gate with Deferred Fault

This block is one stage of a load port. It sits between the address translation lookup and the load result bus. For every load it takes the raw loaded data, the load's reorder tag and the translation outcome: whether the lookup hit, and whether the current privilege level may read the page. A load that passes the check goes out unchanged.

A load whose translation hits but whose permission is denied does not stop the pipe. It goes out with the same latency as a good load. Its data is forced to zero and it carries a fault flag and a cause code, so the retirement logic can raise the fault later if the load actually retires. Dependent operations that run in the meantime only ever see zeros.

When the lookup misses, the load parks in the stage and the stage deasserts its input ready. It waits there until a translation fill arrives, and that fill decides the outcome. A flush input throws away whatever the stage holds.

Top module: `ldperm_gate`

## Requirements
- R1: A load accepted with `xl_hit`=0 produces no result, and `ld_ready` stays 0 in every cycle until a cycle with `fill_valid`=1 (or a flush).
- R2: A load accepted with `xl_hit`=1 and `xl_allow`=0 is not stalled. It appears on the result port with `res_fault`=1 and `res_cause`=2'b01 (permission).
- R3: Whenever `res_valid`=1 and `res_fault`=1, `res_data` is all zeros, whatever data was loaded.
- R4: A load accepted with `xl_hit`=1 has `res_valid`=1 right after the clock edge that accepts it, with the same latency for allowed and denied loads. While `res_ready`=1, a new load can be accepted on every cycle.
- R5: A load accepted with `xl_hit`=1 and `xl_allow`=1 presents `ld_data` unchanged, with `res_fault`=0 and `res_cause`=2'b00.
- R6: `res_tag` equals the `ld_tag` presented with the load that the result belongs to.
- R7: A fill for a stalled load completes that load on the next edge. `fill_present`=0 gives cause 2'b10 (no mapping) with zero data. `fill_present`=1 with `fill_allow`=0 gives cause 2'b01 with zero data. `fill_present`=1 with `fill_allow`=1 gives the original data with cause 2'b00. `res_fault` is 1 exactly when the cause is nonzero.
- R8: `flush`=1 drops a stalled load, a pending result, and a load handshaked in the same cycle. None of them ever produces a result, and the stage is empty afterwards.
- R9: While `res_valid`=1 and `res_ready`=0, the result stays stable and `ld_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop all held and incoming loads |
| ld_valid | input | 1 | Load presented |
| ld_ready | output | 1 | Stage can accept a load |
| ld_tag | input | TAG_W | Reorder tag of the load |
| ld_data | input | DATA_W | Raw loaded data |
| xl_hit | input | 1 | Translation lookup hit |
| xl_allow | input | 1 | Permission granted at current privilege |
| fill_valid | input | 1 | Translation fill for a stalled load |
| fill_present | input | 1 | Fill found a mapping |
| fill_allow | input | 1 | Fill grants permission |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_tag | output | TAG_W | Tag of the result |
| res_data | output | DATA_W | Result data, zero when faulting |
| res_fault | output | 1 | Fault must be raised at retirement |
| res_cause | output | 2 | 00 none, 01 permission, 10 no mapping |

## Verification
A wrong mask or cause register shows up at the result port in the first cycle the faulting load is visible, as nonzero data or a wrong cause. A lost stall state shows up the next cycle after a miss is accepted, as a premature result or `ld_ready` going high. A flush that leaks shows up as a result with a dropped tag, either right after the flush or after a later fill. Each of these can therefore be seen within one or two cycles of the triggering stimulus, and the checks sample right at that point.

// File: rtl/ldperm_gate.sv
module ldperm_gate #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              xl_hit,
  input  logic              xl_allow,
  input  logic              fill_valid,
  input  logic              fill_present,
  input  logic              fill_allow,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  output logic              res_fault,
  output logic [1:0]        res_cause
);
  localparam logic [1:0] CAUSE_NONE  = 2'b00;
  localparam logic [1:0] CAUSE_PERM  = 2'b01;
  localparam logic [1:0] CAUSE_NOMAP = 2'b10;

  typedef enum logic [1:0] {S_EMPTY, S_WAIT, S_FULL} st_t;

  st_t               st;
  logic [TAG_W-1:0]  q_tag;
  logic [DATA_W-1:0] q_data;
  logic [1:0]        q_cause;

  logic       drain, take, fill_take;
  logic [1:0] hit_cause, fill_cause;

  assign drain     = (st == S_FULL) && res_ready;
  assign ld_ready  = (st == S_EMPTY) || drain;
  assign take      = ld_valid && ld_ready && !flush;
  assign fill_take = (st == S_WAIT) && fill_valid && !flush;

  assign hit_cause  = xl_allow ? CAUSE_NONE : CAUSE_PERM;
  assign fill_cause = !fill_present ? CAUSE_NOMAP :
                      (!fill_allow ? CAUSE_PERM : CAUSE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_EMPTY;
      q_tag   <= '0;
      q_data  <= '0;
      q_cause <= CAUSE_NONE;
    end else if (flush) begin
      st <= S_EMPTY;
    end else if (take) begin
      q_tag <= ld_tag;
      if (xl_hit) begin
        st      <= S_FULL;
        q_data  <= ld_data & {DATA_W{xl_allow}};
        q_cause <= hit_cause;
      end else begin
        st      <= S_WAIT;
        q_data  <= ld_data;
        q_cause <= CAUSE_NONE;
      end
    end else if (fill_take) begin
      st      <= S_FULL;
      q_cause <= fill_cause;
      q_data  <= q_data & {DATA_W{fill_cause == CAUSE_NONE}};
    end else if (drain) begin
      st <= S_EMPTY;
    end
  end

  assign res_valid = (st == S_FULL);
  assign res_tag   = q_tag;
  assign res_data  = q_data;
  assign res_cause = q_cause;
  assign res_fault = |q_cause;
endmodule

// File: rtl/ldperm_gate_chk.sv
module ldperm_gate_chk #(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic [TAG_W-1:0]  ld_tag,
  input logic              xl_hit,
  input logic              fill_valid,
  input logic              res_valid,
  input logic              res_ready,
  input logic [TAG_W-1:0]  res_tag,
  input logic [DATA_W-1:0] res_data,
  input logic              res_fault,
  input logic [1:0]        res_cause
);
  AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && !xl_hit && !flush |=> !ld_ready && !res_valid); // R1
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready && !res_valid && !fill_valid && !flush |=> !ld_ready && !res_valid); // R1
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_data == '0); // R3
  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid && ld_ready && xl_hit && !flush |=> res_valid && res_tag == $past(ld_tag)); // R4
  AST_CAUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fault == (res_cause != 2'b00)) && res_cause != 2'b11); // R7
  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !res_valid && ld_ready); // R8
  AST_BP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready && !flush |=> res_valid && $stable(res_data) && $stable(res_tag) && $stable(res_cause)); // R9
  AST_BP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !ld_ready); // R9
endmodule

bind ldperm_gate ldperm_gate_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .ld_tag(ld_tag), .xl_hit(xl_hit), .fill_valid(fill_valid), .res_valid(res_valid),
  .res_ready(res_ready), .res_tag(res_tag), .res_data(res_data), .res_fault(res_fault),
  .res_cause(res_cause)
);

// File: tb/ldperm_gate_bench.sv
`timescale 1ns/1ps
module ldperm_gate_bench;
  localparam int DW = 64;
  localparam int TW = 6;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic ld_valid = 1'b0, xl_hit = 1'b0, xl_allow = 1'b0;
  logic [TW-1:0] ld_tag = '0;
  logic [DW-1:0] ld_data = '0;
  logic fill_valid = 1'b0, fill_present = 1'b0, fill_allow = 1'b0;
  logic res_ready = 1'b1;
  logic ld_ready, res_valid, res_fault;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_data;
  logic [1:0] res_cause;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ldperm_gate #(.DATA_W(DW), .TAG_W(TW)) u_ldperm_gate (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_tag(ld_tag), .ld_data(ld_data), .xl_hit(xl_hit), .xl_allow(xl_allow),
    .fill_valid(fill_valid), .fill_present(fill_present), .fill_allow(fill_allow),
    .res_valid(res_valid), .res_ready(res_ready), .res_tag(res_tag), .res_data(res_data),
    .res_fault(res_fault), .res_cause(res_cause)
  );

  // {allow, tag, data}
  localparam logic [70:0] VEC [8] = '{
    {1'b1, 6'd1,  64'hDEAD_BEEF_0123_4567},
    {1'b0, 6'd2,  64'hFFFF_FFFF_FFFF_FFFF},
    {1'b1, 6'd3,  64'h0000_0000_0000_0000},
    {1'b0, 6'd4,  64'h8000_0000_0000_0001},
    {1'b1, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 6'd0,  64'h5A5A_A5A5_5A5A_A5A5},
    {1'b1, 6'd17, 64'h1234_5678_9ABC_DEF0},
    {1'b0, 6'd42, 64'h0000_0000_0000_0080}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input logic [TW-1:0] t, input logic [DW-1:0] d, input logic [1:0] c);
    chk(res_valid == 1'b1, {req, " valid"}, 64'(res_valid), 64'd1);
    chk(res_tag == t, {req, " tag"}, 64'(res_tag), 64'(t));
    chk(res_data == d, {req, " data"}, res_data, d);
    chk(res_cause == c, {req, " cause"}, 64'(res_cause), 64'(c));
    chk(res_fault == (c != 2'b00), {req, " fault"}, 64'(res_fault), 64'(c != 2'b00));
  endtask

  task automatic present(input bit hit, input bit allow, input logic [TW-1:0] t, input logic [DW-1:0] d);
    ld_valid = 1'b1; xl_hit = hit; xl_allow = allow; ld_tag = t; ld_data = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(res_valid == 1'b0, "reset res_valid", 64'(res_valid), 64'd0);
    chk(ld_ready == 1'b1, "reset ld_ready", 64'(ld_ready), 64'd1);

    // R2 R3 R4 R5 R6: table of hitting loads, one per cycle
    for (int i = 0; i < 8; i++) begin
      present(1'b1, VEC[i][70], VEC[i][69:64], VEC[i][63:0]);
      chk(ld_ready == 1'b1, "R4 ready back-to-back", 64'(ld_ready), 64'd1);
      @(posedge clk);
      @(negedge clk);
      if (VEC[i][70]) chk_res("R5 R6 pass", VEC[i][69:64], VEC[i][63:0], 2'b00);
      else            chk_res("R2 R3 R6 denied", VEC[i][69:64], '0, 2'b01);
    end
    ld_valid = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R4 drained", 64'(res_valid), 64'd0);

    // R1 R7: miss, wait, fill with mapping and permission
    present(1'b0, 1'b1, 6'd9, 64'hCAFE_F00D_0000_1111);
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(ld_ready == 1'b0, "R1 stalled ready", 64'(ld_ready), 64'd0);
      chk(res_valid == 1'b0, "R1 stalled no result", 64'(res_valid), 64'd0);
      @(negedge clk);
    end
    fill_valid = 1'b1; fill_present = 1'b1; fill_allow = 1'b1;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    chk_res("R7 fill pass", 6'd9, 64'hCAFE_F00D_0000_1111, 2'b00);
    @(negedge clk);

    // R7: fill with no mapping
    present(1'b0, 1'b1, 6'd10, 64'h1111_2222_3333_4444);
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    fill_valid = 1'b1; fill_present = 1'b0; fill_allow = 1'b1;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    chk_res("R7 nomap", 6'd10, '0, 2'b10);
    @(negedge clk);

    // R7: fill with mapping but denied
    present(1'b0, 1'b1, 6'd11, 64'h7777_8888_9999_AAAA);
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    fill_valid = 1'b1; fill_present = 1'b1; fill_allow = 1'b0;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    chk_res("R7 fill denied", 6'd11, '0, 2'b01);
    @(negedge clk);

    // R9: backpressure
    res_ready = 1'b0;
    present(1'b1, 1'b1, 6'd20, 64'h0BAD_CAFE_0BAD_CAFE);
    @(posedge clk); @(negedge clk);
    present(1'b1, 1'b1, 6'd21, 64'h1);
    for (int k = 0; k < 3; k++) begin
      chk(ld_ready == 1'b0, "R9 ready low", 64'(ld_ready), 64'd0);
      chk_res("R9 held", 6'd20, 64'h0BAD_CAFE_0BAD_CAFE, 2'b00);
      @(negedge clk);
    end
    ld_valid = 1'b0;
    res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(res_valid == 1'b0, "R9 released", 64'(res_valid), 64'd0);

    // R8: flush a stalled load, then a late fill must not produce a result
    present(1'b0, 1'b1, 6'd30, 64'h3);
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
    chk(ld_ready == 1'b1, "R8 stalled flushed ready", 64'(ld_ready), 64'd1);
    fill_valid = 1'b1; fill_present = 1'b1; fill_allow = 1'b1;
    @(posedge clk); @(negedge clk);
    fill_valid = 1'b0;
    chk(res_valid == 1'b0, "R8 no result after flush", 64'(res_valid), 64'd0);

    // R8: flush a pending result
    res_ready = 1'b0;
    present(1'b1, 1'b0, 6'd31, 64'h4);
    @(posedge clk); @(negedge clk);
    ld_valid = 1'b0;
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0;
    chk(res_valid == 1'b0, "R8 pending result dropped", 64'(res_valid), 64'd0);
    res_ready = 1'b1;

    // R8: flush in the same cycle as a handshake
    present(1'b1, 1'b1, 6'd32, 64'h5);
    flush = 1'b1;
    @(posedge clk); @(negedge clk);
    flush = 1'b0; ld_valid = 1'b0;
    chk(res_valid == 1'b0, "R8 same-cycle load dropped", 64'(res_valid), 64'd0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 stays empty", 64'(res_valid), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule